// File: doc/BRIEF.md
# Mode-Addressed Serial Control Slave

This block is a slave port on a shared three-wire serial control bus: a bit clock, a bidirectional data line and a per-device enable. Two mode lines pick one of four transfer types. Two of them are host writes: an 8-bit extended-settings byte and a 16-bit settings word. One is a host read of a status word. The fourth, allocation, is not served by this port. The bus lines are brought into the system clock domain through synchronisers, and every bus event is detected from edges seen there.

When a write completes, the block raises a one-cycle "word received" strobe that carries the word and its mode. On a status read it shifts out a status word. That word copies a mirrored remote status register except for two ready-to-receive bits, which are generated locally. Receiving a word clears the matching ready flag. A "forwarded" pulse from downstream logic sets it again. The block drives the data line only during a status read with enable high, and releases it otherwise.

Top module: `mcs_ctl_slave`

## Requirements
- R1: After reset the data output enable is 0, the strobe is 0, and both ready-to-receive bits read back as 1.
- R2: With enable low, the data output enable is 0 and bit-clock edges produce no strobe.
- R3: The mode lines are captured when enable rises and hold for the whole transaction: 00 means extended settings (8-bit write), 10 means settings (16-bit write), 11 means status read, and 01 (allocation) is ignored.
- R4: Each byte travels least significant bit first, and data is sampled on the rising edge of the bit clock.
- R5: In a 16-bit unit the high byte goes first, with enable held at 1 across both bytes. A settings write produces one strobe with wr_mode_o=10 and wr_data_o equal to the word.
- R6: An extended-settings write produces one strobe after 8 bits with wr_mode_o=00 and wr_data_o={8'h00, byte}. Further bits in the same transaction are ignored.
- R7: The status word places ready S in bit 9 and ready E in bit 8. Every other bit is copied from remote_stat_i. It is sent high byte first, each byte LSB first, and the output changes after each rising edge of the bit clock.
- R8: A status read may stop after 8 bits. The host then holds the upper byte, and the next read starts again from the beginning.
- R9: A settings strobe clears ready S, and an extended strobe clears ready E. Each flag stays 0 until its forwarded pulse arrives.
- R10: A write that arrives while its ready flag is 0, or that ends before its last bit, produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bit clock from the host |
| bus_en_i | input | 1 | Per-device enable, active high |
| bus_mode_i | input | 2 | Transfer type select |
| bus_din_i | input | 1 | Serial data line, input side |
| bus_dout_o | output | 1 | Serial data line, output side |
| bus_doe_o | output | 1 | Output enable for the data line |
| remote_stat_i | input | 16 | Mirrored remote status register |
| fwd_set_done_i | input | 1 | Pulse: settings word forwarded, sets ready S |
| fwd_ext_done_i | input | 1 | Pulse: extended byte forwarded, sets ready E |
| wr_valid_o | output | 1 | One-cycle word received strobe |
| wr_mode_o | output | 2 | Mode of the received word |
| wr_data_o | output | 16 | Received word |

## Verification
The bench builds the block with its defaults: 8-bit units, two synchroniser stages, and ready bits at positions 9 and 8. With these values both ready bits sit in the upper byte, so an 8-bit status read reaches them, and the high-byte-first ordering of a settings word can be told apart from a plain LSB-first 16-bit shift. The bit clock runs at 16 system clocks per period, which leaves room for the synchroniser latency between one rising edge and the host's next sample.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
   typedef enum logic [1:0] {
      MODE_EXT   = 2'b00,
      MODE_ALLOC = 2'b01,
      MODE_SET   = 2'b10,
      MODE_STAT  = 2'b11
   } mode_e;
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mcs_framer.sv
module mcs_framer
   import mcs_pkg::*;
#(
   parameter int UNIT_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en_rise,
   input  logic                  en_lvl,
   input  logic                  bit_rise,
   input  logic                  din,
   input  mode_e                 mode_in,
   output mode_e                 mode_q,
   output logic                  active_q,
   output logic                  word_v_q,
   output logic [2*UNIT_W-1:0]   word_q
);
   localparam int WORD_W = 2 * UNIT_W;
   localparam int CNT_W  = $clog2(WORD_W + 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [UNIT_W-1:0] sr_q, hi_q, sr_nx;
   logic              done_q;
   logic              is_wr, shift_en;

   assign is_wr    = (mode_q == MODE_EXT) || (mode_q == MODE_SET);
   assign shift_en = active_q & en_lvl & bit_rise & is_wr & ~done_q;
   assign sr_nx    = {din, sr_q[UNIT_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_EXT;
         active_q <= 1'b0;
         word_v_q <= 1'b0;
         word_q   <= '0;
         cnt_q    <= '0;
         sr_q     <= '0;
         hi_q     <= '0;
         done_q   <= 1'b0;
      end else begin
         word_v_q <= 1'b0;
         if (en_rise) begin
            active_q <= 1'b1;
            mode_q   <= mode_in;
            cnt_q    <= '0;
            done_q   <= 1'b0;
         end else if (!en_lvl) begin
            active_q <= 1'b0;
         end else if (shift_en) begin
            sr_q  <= sr_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(UNIT_W - 1)) begin
               hi_q <= sr_nx;
               if (mode_q == MODE_EXT) begin
                  word_v_q <= 1'b1;
                  word_q   <= {{UNIT_W{1'b0}}, sr_nx};
                  done_q   <= 1'b1;
               end
            end
            if (cnt_q == CNT_W'(WORD_W - 1)) begin
               word_v_q <= 1'b1;
               word_q   <= {hi_q, sr_nx};
               done_q   <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mcs_stat_tx.sv
module mcs_stat_tx #(
   parameter int UNIT_W    = 8,
   parameter int RDY_S_POS = 9,
   parameter int RDY_E_POS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_rise,
   input  logic                en_lvl,
   input  logic                bit_rise,
   input  logic                active,
   input  logic                is_stat,
   input  logic [2*UNIT_W-1:0] remote,
   input  logic                rdy_s,
   input  logic                rdy_e,
   output logic                dout,
   output logic                doe
);
   localparam int WORD_W = 2 * UNIT_W;
   localparam logic [WORD_W-1:0] RDY_MASK =
      (WORD_W'(1) << RDY_S_POS) | (WORD_W'(1) << RDY_E_POS);

   logic [WORD_W-1:0] word, stream_q;

   assign word = (remote & ~RDY_MASK)
               | (WORD_W'(rdy_s) << RDY_S_POS)
               | (WORD_W'(rdy_e) << RDY_E_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stream_q <= '0;
      end else if (en_rise) begin
         stream_q <= {word[UNIT_W-1:0], word[WORD_W-1:UNIT_W]};
      end else if (bit_rise && active && is_stat) begin
         stream_q <= stream_q >> 1;
      end
   end

   assign dout = stream_q[0];
   assign doe  = active & en_lvl & is_stat;
endmodule

// File: rtl/mcs_ready.sv
module mcs_ready #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] take_i,
   input  logic [N-1:0] fwd_i,
   output logic [N-1:0] rdy_o
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         rdy_o[i] <= 1'b1;
         else if (take_i[i]) rdy_o[i] <= 1'b0;
         else if (fwd_i[i])  rdy_o[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/mcs_ctl_slave.sv
module mcs_ctl_slave
   import mcs_pkg::*;
#(
   parameter int UNIT_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RDY_S_POS   = 9,
   parameter int RDY_E_POS   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_clk_i,
   input  logic                bus_en_i,
   input  logic [1:0]          bus_mode_i,
   input  logic                bus_din_i,
   output logic                bus_dout_o,
   output logic                bus_doe_o,
   input  logic [2*UNIT_W-1:0] remote_stat_i,
   input  logic                fwd_set_done_i,
   input  logic                fwd_ext_done_i,
   output logic                wr_valid_o,
   output logic [1:0]          wr_mode_o,
   output logic [2*UNIT_W-1:0] wr_data_o
);
   localparam int WORD_W = 2 * UNIT_W;
   localparam int SYN_W  = 5;

   if (UNIT_W < 2) begin : g_bad_unit
      $error("UNIT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RDY_S_POS == RDY_E_POS || RDY_S_POS >= WORD_W || RDY_E_POS >= WORD_W
       || RDY_S_POS < 0 || RDY_E_POS < 0) begin : g_bad_pos
      $error("ready bit positions must differ and fit in the word");
   end

   logic [SYN_W-1:0] syn_q;
   logic             sclk_s, en_s, din_s;
   logic [1:0]       mode_s;
   logic             sclk_prev, en_prev;
   logic             bit_rise, en_rise;

   mcs_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({bus_mode_i, bus_din_i, bus_en_i, bus_clk_i}),
      .q_o   (syn_q)
   );

   assign {mode_s, din_s, en_s, sclk_s} = syn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         en_prev   <= 1'b0;
      end else begin
         sclk_prev <= sclk_s;
         en_prev   <= en_s;
      end
   end

   assign bit_rise = sclk_s & ~sclk_prev;
   assign en_rise  = en_s & ~en_prev;

   mode_e             mode_q;
   logic              active_q, word_v;
   logic [WORD_W-1:0] word;

   mcs_framer #(.UNIT_W(UNIT_W)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_rise  (en_rise),
      .en_lvl   (en_s),
      .bit_rise (bit_rise),
      .din      (din_s),
      .mode_in  (mode_e'(mode_s)),
      .mode_q   (mode_q),
      .active_q (active_q),
      .word_v_q (word_v),
      .word_q   (word)
   );

   logic [1:0] rdy, take;
   logic       rdy_s, rdy_e, accept;

   assign rdy_s  = rdy[0];
   assign rdy_e  = rdy[1];
   assign accept = ((mode_q == MODE_SET) & rdy_s) | ((mode_q == MODE_EXT) & rdy_e);

   assign wr_valid_o = word_v & accept;
   assign wr_mode_o  = mode_q;
   assign wr_data_o  = word;

   assign take = {wr_valid_o & (mode_q == MODE_EXT), wr_valid_o & (mode_q == MODE_SET)};

   mcs_ready #(.N(2)) u_ready (
      .clk    (clk),
      .rst_n  (rst_n),
      .take_i (take),
      .fwd_i  ({fwd_ext_done_i, fwd_set_done_i}),
      .rdy_o  (rdy)
   );

   mcs_stat_tx #(
      .UNIT_W    (UNIT_W),
      .RDY_S_POS (RDY_S_POS),
      .RDY_E_POS (RDY_E_POS)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_rise  (en_rise),
      .en_lvl   (en_s),
      .bit_rise (bit_rise),
      .active   (active_q),
      .is_stat  (mode_q == MODE_STAT),
      .remote   (remote_stat_i),
      .rdy_s    (rdy_s),
      .rdy_e    (rdy_e),
      .dout     (bus_dout_o),
      .doe      (bus_doe_o)
   );
endmodule

// File: rtl/mcs_ctl_chk.sv
module mcs_ctl_chk
   import mcs_pkg::*;
#(
   parameter int UNIT_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                en_s,
   input logic                bus_doe_o,
   input logic                wr_valid_o,
   input logic [1:0]          wr_mode_o,
   input logic [2*UNIT_W-1:0] wr_data_o,
   input logic                rdy_s,
   input logic                rdy_e
);
   // R2
   doe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> !bus_doe_o);

   // R5
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |=> !wr_valid_o);

   // R3
   strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> (wr_mode_o == MODE_EXT || wr_mode_o == MODE_SET));

   // R6
   ext_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && wr_mode_o == MODE_EXT) |-> (wr_data_o[2*UNIT_W-1:UNIT_W] == '0));

   // R9
   rdy_s_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_s) |-> $past(wr_valid_o && wr_mode_o == MODE_SET));

   // R9
   rdy_e_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_e) |-> $past(wr_valid_o && wr_mode_o == MODE_EXT));

   // R10
   set_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && wr_mode_o == MODE_SET) |-> rdy_s);

   // R10
   ext_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && wr_mode_o == MODE_EXT) |-> rdy_e);
endmodule

bind mcs_ctl_slave mcs_ctl_chk #(.UNIT_W(UNIT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_s       (en_s),
   .bus_doe_o  (bus_doe_o),
   .wr_valid_o (wr_valid_o),
   .wr_mode_o  (wr_mode_o),
   .wr_data_o  (wr_data_o),
   .rdy_s      (rdy_s),
   .rdy_e      (rdy_e)
);

// File: tb/sim_mcs_ctl_slave.sv
module sim_mcs_ctl_slave;
   localparam int CLK_PERIOD = 10;
   localparam int HP         = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_clk = 1'b0, bus_en = 1'b0, bus_din = 1'b0;
   logic [1:0]  bus_mode = 2'b00;
   logic        bus_dout, bus_doe;
   logic [15:0] remote = 16'h0000;
   logic        fwd_s = 1'b0, fwd_e = 1'b0;
   logic        wr_valid;
   logic [1:0]  wr_mode;
   logic [15:0] wr_data;

   int total = 0, bad = 0;
   int strobes = 0;
   logic [15:0] last_data = '0;
   logic [1:0]  last_mode = '0;
   int doe_seen = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcs_ctl_slave u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_clk_i      (bus_clk),
      .bus_en_i       (bus_en),
      .bus_mode_i     (bus_mode),
      .bus_din_i      (bus_din),
      .bus_dout_o     (bus_dout),
      .bus_doe_o      (bus_doe),
      .remote_stat_i  (remote),
      .fwd_set_done_i (fwd_s),
      .fwd_ext_done_i (fwd_e),
      .wr_valid_o     (wr_valid),
      .wr_mode_o      (wr_mode),
      .wr_data_o      (wr_data)
   );

   always @(posedge clk) begin
      if (wr_valid) begin
         strobes   <= strobes + 1;
         last_data <= wr_data;
         last_mode <= wr_mode;
      end
      if (bus_doe) doe_seen <= doe_seen + 1;
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] exp_stat(input logic [15:0] r, input logic s, input logic e);
      logic [15:0] w;
      w    = r;
      w[9] = s;
      w[8] = e;
      return w;
   endfunction

   function automatic logic [23:0] word_stream(input logic [15:0] w);
      return {8'h00, w[7:0], w[15:8]};
   endfunction

   task automatic host_write(input logic [1:0] mode, input int nbits, input logic [23:0] stream);
      bus_mode = mode;
      wait_n(4);
      bus_en = 1'b1;
      wait_n(2*HP);
      for (int i = 0; i < nbits; i++) begin
         bus_din = stream[i];
         wait_n(HP);
         bus_clk = 1'b1;
         wait_n(HP);
         bus_clk = 1'b0;
      end
      wait_n(HP);
      bus_en = 1'b0;
      wait_n(4*HP);
   endtask

   task automatic host_read(input int nbits, output logic [15:0] w, output int doe_low);
      w = '0;
      doe_low = 0;
      bus_mode = 2'b11;
      wait_n(4);
      bus_en = 1'b1;
      wait_n(2*HP);
      for (int i = 0; i < nbits; i++) begin
         if (!bus_doe) doe_low++;
         if (i < 8) w[8+i] = bus_dout;
         else       w[i-8] = bus_dout;
         bus_clk = 1'b1;
         wait_n(HP);
         bus_clk = 1'b0;
         wait_n(HP);
      end
      bus_en = 1'b0;
      wait_n(4*HP);
   endtask

   task automatic pulse_fwd(input bit s, input bit e);
      fwd_s = s;
      fwd_e = e;
      wait_n(1);
      fwd_s = 1'b0;
      fwd_e = 1'b0;
      wait_n(2);
   endtask

   task automatic t_reset();
      check("R1 doe after reset", 16'(bus_doe), 16'h0);
      check("R1 strobe after reset", 16'(strobes), 16'h0);
   endtask

   task automatic t_status_idle();
      logic [15:0] w;
      int dl;
      remote = 16'h5CA6;
      host_read(16, w, dl);
      check("R1 R7 status at idle", w, exp_stat(16'h5CA6, 1'b1, 1'b1));
      check("R7 doe during read", 16'(dl), 16'h0);
      check("R2 doe released after read", 16'(bus_doe), 16'h0);
   endtask

   task automatic t_ext_write();
      int s0 = strobes;
      host_write(2'b00, 8, 24'h0000A5);
      check("R6 ext strobe count", 16'(strobes - s0), 16'h1);
      check("R4 R6 ext data", last_data, 16'h00A5);
      check("R3 ext mode", 16'(last_mode), 16'h0);
   endtask

   task automatic t_set_write();
      int s0 = strobes;
      host_write(2'b10, 16, word_stream(16'h1234));
      check("R5 set strobe count", 16'(strobes - s0), 16'h1);
      check("R5 set data", last_data, 16'h1234);
      check("R3 set mode", 16'(last_mode), 16'h2);
   endtask

   task automatic t_not_ready();
      logic [15:0] w;
      int dl;
      int s0;
      host_read(16, w, dl);
      check("R9 status both cleared", w, exp_stat(16'h5CA6, 1'b0, 1'b0));
      s0 = strobes;
      host_write(2'b10, 16, word_stream(16'hBEEF));
      host_write(2'b00, 8, 24'h00005A);
      check("R10 dropped while not ready", 16'(strobes - s0), 16'h0);
   endtask

   task automatic t_forward();
      logic [15:0] w;
      int dl;
      pulse_fwd(1'b1, 1'b0);
      host_read(16, w, dl);
      check("R9 ready S restored", w, exp_stat(16'h5CA6, 1'b1, 1'b0));
      pulse_fwd(1'b0, 1'b1);
      host_read(16, w, dl);
      check("R9 ready E restored", w, exp_stat(16'h5CA6, 1'b1, 1'b1));
   endtask

   task automatic t_short_read();
      logic [15:0] w;
      int dl;
      remote = 16'h813C;
      host_read(8, w, dl);
      check("R8 short read upper byte", w[15:8], exp_stat(16'h813C, 1'b1, 1'b1) >> 8);
      host_read(16, w, dl);
      check("R8 full read after short", w, exp_stat(16'h813C, 1'b1, 1'b1));
   endtask

   task automatic t_alloc_ignored();
      int s0 = strobes;
      int d0 = doe_seen;
      host_write(2'b01, 16, word_stream(16'hFFFF));
      check("R3 alloc no strobe", 16'(strobes - s0), 16'h0);
      check("R3 alloc no drive", 16'(doe_seen - d0), 16'h0);
   endtask

   task automatic t_disabled();
      int s0 = strobes;
      int d0 = doe_seen;
      bus_mode = 2'b10;
      wait_n(4);
      for (int i = 0; i < 16; i++) begin
         bus_din = i[0];
         wait_n(HP);
         bus_clk = 1'b1;
         wait_n(HP);
         bus_clk = 1'b0;
      end
      bus_mode = 2'b11;
      wait_n(4*HP);
      check("R2 no strobe while disabled", 16'(strobes - s0), 16'h0);
      check("R2 no drive while disabled", 16'(doe_seen - d0), 16'h0);
   endtask

   task automatic t_partial_and_extra();
      logic [15:0] w;
      int dl;
      int s0 = strobes;
      host_write(2'b10, 8, 24'h0000FF);
      check("R10 partial set no strobe", 16'(strobes - s0), 16'h0);
      host_read(16, w, dl);
      check("R10 ready S still set", w, exp_stat(16'h813C, 1'b1, 1'b1));
      s0 = strobes;
      host_write(2'b00, 12, 24'h000F3C);
      check("R6 extra bits one strobe", 16'(strobes - s0), 16'h1);
      check("R6 extra bits data", last_data, 16'h003C);
      pulse_fwd(1'b0, 1'b1);
   endtask

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      wait_n(5);
      t_reset();
      t_status_idle();
      t_ext_write();
      t_set_write();
      t_not_ready();
      t_forward();
      t_short_read();
      t_alloc_ignored();
      t_disabled();
      t_partial_and_extra();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule